// File: doc/BRIEF.md
# Channel Power-Saving Sequencer

This block sequences the power of a single transmit or receive channel around a frame-enable input. Three power-saving levels trade idle power against start-up work. At level 0 the regulator and the PLL stay up between frames. At level 1 the PLL is switched off after each frame. At level 2 the regulator is switched off as well. When a frame starts, the sequencer restores whatever is off, in a fixed order: the regulator, then the PLL, then PLL tuning. Channel analog power comes on a programmed number of cycles after enable is first seen. When the frame ends, the analog power goes off first and the level-dependent supplies follow.

Each restore step ends on a done strobe from the analog side or, if no strobe comes, on a timeout. The programmed rise-to-analog delay can be written only while the block is idle and enable is low. A request for a level is accepted only if that delay is longer than the extra start-up time the level needs. A rejected request keeps the previous level and sets a sticky error flag. A force-tune input adds a PLL tuning step at every frame start, at any level. This covers transmit and receive sharing one LO on different frequencies.

Top module: `chan_pwr_seq`

## Requirements
- R1: After reset, `reg_on` and `pll_on` are 1, `ana_on` and `lvl_reject` are 0, `lvl_now` is 0 and `seq_idle` is 1. The rise delay is 30.
- R2: On `lvl_req_valid`, the value in `lvl_req` is handled as follows. Value 0 is always accepted. Value 1 is accepted only if the rise delay is greater than 10. Value 2 is accepted only if the rise delay is greater than 20. Value 3 is always rejected. An accepted value appears on `lvl_now` one cycle later. A rejected one leaves `lvl_now` unchanged and sets `lvl_reject`, which stays set until reset.
- R3: A `dly_wr` pulse loads `dly_val` into the rise delay only while `seq_idle` is 1 and `ch_en` is 0; otherwise it has no effect. A level request in the same cycle as an accepted write is judged against the old delay.
- R4: When the restore steps finish in time, `ana_on` rises exactly max(delay,1) cycles after the clock edge that first samples `ch_en` high while idle.
- R5: At frame start, each supply that is off is restored in this order: regulator (`reg_on` rises), then PLL (`pll_on` rises), then one tuning step. Each step lasts until its done strobe is sampled high, or 16 cycles at most. `ana_on` waits for the last step to finish.
- R6: With `tune_force` high, a tuning step (`pll_tune` high) runs at frame start even at level 0 with all supplies on. Without it, and with the PLL on, no tuning step runs.
- R7: After the edge that samples `ch_en` low with `ana_on` high, `ana_on` falls 4 cycles later. For a frame run at level 1 or 2, `pll_on` falls 3 cycles after that. For level 2, `reg_on` falls a further 3 cycles later. The block is then idle.
- R8: An enable rise during power-down is held. The new frame starts on the edge after `seq_idle` returns, and no supply comes back up before then.
- R9: `ana_on` and `pll_tune` are only ever high while both `reg_on` and `pll_on` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 1 | Channel frame enable |
| lvl_req_valid | input | 1 | Level request strobe |
| lvl_req | input | 2 | Requested power-saving level |
| dly_wr | input | 1 | Rise-delay write strobe |
| dly_val | input | DW | New rise delay in cycles |
| tune_force | input | 1 | Tune the PLL at every frame start |
| reg_done | input | 1 | Regulator power-up done strobe |
| pll_done | input | 1 | PLL power-up done strobe |
| tune_done | input | 1 | PLL tuning done strobe |
| reg_on | output | 1 | Regulator enable |
| pll_on | output | 1 | PLL enable |
| pll_tune | output | 1 | PLL tuning in progress |
| ana_on | output | 1 | Channel analog power |
| seq_idle | output | 1 | Sequencer idle |
| lvl_now | output | 2 | Active power-saving level |
| lvl_reject | output | 1 | Sticky level-rejection flag |

## Verification
A delay write and a level request can land in the same cycle. The acceptance of the level must then use the delay that was in force before the write. The bench provokes this directly, by writing a delay that would allow level 2 in the same cycle as a level-2 request made under a delay that forbids it. It also lets random idle-time traffic overlap the two strobes. It judges the result from `lvl_now` and `lvl_reject`, against a model that applies the level check before it updates the delay.

// File: rtl/chan_pwr_pkg.sv
// Shared types for the channel power sequencer.
// Assumes: levels are 2-bit codes; code 3 is never a valid level.
package chan_pwr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_REG_UP, ST_PLL_UP, ST_TUNE, ST_WAIT_ANA,
        ST_ON, ST_FALL, ST_PLL_DN, ST_REG_DN
    } seq_st_t;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL0 = 2'd0;
    localparam lvl_t LVL2 = 2'd2;
endpackage

// File: rtl/chan_lvl_gate.sv
// Holds the rise-to-analog delay and the active level, and admits a level
// only when the held delay exceeds that level's extra start-up time.
// Assumes: wr_open is high only while the sequencer is idle and disabled.
module chan_lvl_gate
    import chan_pwr_pkg::*;
#(
    parameter int DW      = 8,
    parameter int T_UP1   = 10,
    parameter int T_UP2   = 20,
    parameter int DLY_RST = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_v,
    input  lvl_t          req_lvl,
    input  logic          wr,
    input  logic [DW-1:0] wr_val,
    input  logic          wr_open,
    output logic [DW-1:0] dly_q,
    output lvl_t          lvl_q,
    output logic          err_q
);
    logic [3:0] lvl_ok;
    logic       accept;

    // Per-code admission against the currently held delay
    for (genvar g = 0; g < 4; g++) begin : g_ok
        if (g == 0) begin : g_free
            assign lvl_ok[g] = 1'b1;
        end else if (g == 3) begin : g_bad
            assign lvl_ok[g] = 1'b0;
        end else begin : g_chk
            assign lvl_ok[g] = dly_q > DW'(g == 1 ? T_UP1 : T_UP2);
        end
    end

    assign accept = lvl_ok[req_lvl];

    // Delay register, writable only through the open window
    always_ff @(posedge clk) begin
        if (!rst_n)               dly_q <= DW'(DLY_RST);
        else if (wr && wr_open)   dly_q <= wr_val;
    end

    // Active level and sticky rejection flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL0;
            err_q <= 1'b0;
        end else if (req_v) begin
            if (accept) lvl_q <= req_lvl;
            else        err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/chan_step_timer.sv
// Counts cycles inside one sequencer step and flags its end on a done
// strobe or when the limit is reached.
// Assumes: lim >= 1; restart pulses on every state change.
module chan_step_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          done,
    input  logic [CW-1:0] lim,
    output logic          fire
);
    logic [CW-1:0] cnt;

    assign fire = done || (cnt >= lim - CW'(1));

    // Step cycle counter, held once the step has ended
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (restart)  cnt <= '0;
        else if (!fire)    cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/chan_pwr_seq.sv
// Channel power sequencer: restores supplies that are off at frame start,
// turns analog on after the programmed delay, and powers down by level at
// frame end. Assumes strobes are synchronous to clk.
module chan_pwr_seq
    import chan_pwr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int T_UP1    = 10,
    parameter int T_UP2    = 20,
    parameter int DLY_RST  = 30,
    parameter int FALL_DLY = 4,
    parameter int DN_CYC   = 3,
    parameter int TMO      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_en,
    input  logic          lvl_req_valid,
    input  logic [1:0]    lvl_req,
    input  logic          dly_wr,
    input  logic [DW-1:0] dly_val,
    input  logic          tune_force,
    input  logic          reg_done,
    input  logic          pll_done,
    input  logic          tune_done,
    output logic          reg_on,
    output logic          pll_on,
    output logic          pll_tune,
    output logic          ana_on,
    output logic          seq_idle,
    output logic [1:0]    lvl_now,
    output logic          lvl_reject
);
    localparam int CW = $clog2(TMO + FALL_DLY + DN_CYC + 1);

    seq_st_t       st, st_n;
    lvl_t          frm_lvl;
    logic [DW-1:0] dly_q;
    logic [DW-1:0] rise_cnt;
    logic [CW-1:0] step_lim;
    logic          step_done, fire;

    assign seq_idle = (st == ST_IDLE);
    assign pll_tune = (st == ST_TUNE);

    chan_lvl_gate #(.DW(DW), .T_UP1(T_UP1), .T_UP2(T_UP2), .DLY_RST(DLY_RST)) u_gate (
        .clk(clk), .rst_n(rst_n), .req_v(lvl_req_valid), .req_lvl(lvl_req),
        .wr(dly_wr), .wr_val(dly_val), .wr_open(seq_idle && !ch_en),
        .dly_q(dly_q), .lvl_q(lvl_now), .err_q(lvl_reject)
    );

    chan_step_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(st_n != st), .done(step_done),
        .lim(step_lim), .fire(fire)
    );

    // Pick the strobe and the limit of the current step
    always_comb begin
        step_done = 1'b0;
        step_lim  = CW'(TMO);
        case (st)
            ST_REG_UP:           step_done = reg_done;
            ST_PLL_UP:           step_done = pll_done;
            ST_TUNE:             step_done = tune_done;
            ST_FALL:             step_lim  = CW'(FALL_DLY);
            ST_PLL_DN, ST_REG_DN: step_lim = CW'(DN_CYC);
            default:             step_lim  = CW'(TMO);
        endcase
    end

    // Next-state decision
    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE: if (ch_en) begin
                if (!reg_on)         st_n = ST_REG_UP;
                else if (!pll_on)    st_n = ST_PLL_UP;
                else if (tune_force) st_n = ST_TUNE;
                else                 st_n = ST_WAIT_ANA;
            end
            ST_REG_UP:   if (!ch_en) st_n = ST_FALL; else if (fire) st_n = ST_PLL_UP;
            ST_PLL_UP:   if (!ch_en) st_n = ST_FALL; else if (fire) st_n = ST_TUNE;
            ST_TUNE:     if (!ch_en) st_n = ST_FALL; else if (fire) st_n = ST_WAIT_ANA;
            ST_WAIT_ANA: if (!ch_en) st_n = ST_FALL; else if (rise_cnt >= dly_q) st_n = ST_ON;
            ST_ON:       if (!ch_en) st_n = ST_FALL;
            ST_FALL:     if (fire) st_n = (frm_lvl != LVL0) ? ST_PLL_DN : ST_IDLE;
            ST_PLL_DN:   if (fire) st_n = (frm_lvl == LVL2) ? ST_REG_DN : ST_IDLE;
            ST_REG_DN:   if (fire) st_n = ST_IDLE;
            default:     st_n = ST_IDLE;
        endcase
    end

    // State register and frame-level latch at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            frm_lvl <= LVL0;
        end else begin
            st <= st_n;
            if (seq_idle && st_n != ST_IDLE) frm_lvl <= lvl_now;
        end
    end

    // Cycles since the enable was taken, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || seq_idle) rise_cnt <= DW'(1);
        else if (rise_cnt != '1) rise_cnt <= rise_cnt + DW'(1);
    end

    // Supply and analog enables, switched on step boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_on <= 1'b1;
            pll_on <= 1'b1;
            ana_on <= 1'b0;
        end else begin
            if (st_n == ST_REG_UP && st != ST_REG_UP)      reg_on <= 1'b1;
            else if (st == ST_REG_DN && st_n != ST_REG_DN) reg_on <= 1'b0;
            if (st_n == ST_PLL_UP && st != ST_PLL_UP)      pll_on <= 1'b1;
            else if (st == ST_PLL_DN && st_n != ST_PLL_DN) pll_on <= 1'b0;
            if (st == ST_WAIT_ANA && st_n == ST_ON)        ana_on <= 1'b1;
            else if (st == ST_FALL && st_n != ST_FALL)     ana_on <= 1'b0;
        end
    end
endmodule

// File: rtl/chan_pwr_seq_chk.sv
// Protocol checks on the sequencer ports, bound into every instance.
module chan_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ch_en,
    input logic       reg_on,
    input logic       pll_on,
    input logic       pll_tune,
    input logic       ana_on,
    input logic       seq_idle,
    input logic [1:0] lvl_now,
    input logic       lvl_reject
);
    // R9
    ana_needs_supplies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ana_on |-> (reg_on && pll_on));
    // R9
    tune_needs_supplies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_tune |-> (reg_on && pll_on));
    // R8
    reg_up_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_on) |-> $past(seq_idle));
    // R4
    ana_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ana_on) |-> $past(ch_en));
    // R2
    reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_reject |=> lvl_reject);
    // R2
    reject_keeps_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_reject) |-> $stable(lvl_now));
    // R2
    lvl_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_now != 2'd3);
endmodule

bind chan_pwr_seq chan_pwr_seq_chk u_chk (.*);

// File: tb/chan_pwr_seq_test.sv
module chan_pwr_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ch_en = 1'b0, lvl_req_valid = 1'b0, dly_wr = 1'b0, tune_force = 1'b0;
    logic [1:0] lvl_req = '0;
    logic [7:0] dly_val = '0;
    logic       reg_done = 1'b1, pll_done = 1'b1, tune_done = 1'b1;
    logic       reg_on, pll_on, pll_tune, ana_on, seq_idle, lvl_reject;
    logic [1:0] lvl_now;
    int         vecs = 0, errs = 0;
    bit         tune_seen = 1'b0;
    int         m_dly = 30, m_lvl = 0, m_err = 0;

    always #5 clk = ~clk;

    chan_pwr_seq uut (.*);

    function automatic bit exp_ok(int l, int d);
        return (l == 0) || (l == 1 && d > 10) || (l == 2 && d > 20);
    endfunction

    task automatic chk(string req, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (pll_tune) tune_seen = 1'b1;
    endtask

    task automatic lvl_cmd(int l);
        lvl_req_valid = 1'b1;
        lvl_req = 2'(l);
        step();
        lvl_req_valid = 1'b0;
    endtask

    task automatic dly_cmd(int d);
        dly_wr = 1'b1;
        dly_val = 8'(d);
        step();
        dly_wr = 1'b0;
    endtask

    // Raise enable and count cycles to analog on
    task automatic rise_measure(string req, int exp);
        int n = 0;
        tune_seen = 1'b0;
        ch_en = 1'b1;
        step();
        while (!ana_on && n < 300) begin
            step();
            n++;
        end
        chk(req, n, exp);
        chk("R9 supplies at analog on", int'(reg_on && pll_on), 1);
        step();
    endtask

    // Drop enable and follow the power-down sequence
    task automatic fall_check(string req, int l);
        ch_en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            step();
            chk({req, " ana"}, int'(ana_on), int'(i < 4));
            chk({req, " pll"}, int'(pll_on), (l == 0) ? 1 : int'(i < 7));
            chk({req, " reg"}, int'(reg_on), (l == 2) ? int'(i < 10) : 1);
        end
        chk({req, " idle"}, int'(seq_idle), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd5821));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 reg_on", int'(reg_on), 1);
        chk("R1 pll_on", int'(pll_on), 1);
        chk("R1 ana_on", int'(ana_on), 0);
        chk("R1 lvl_now", int'(lvl_now), 0);
        chk("R1 lvl_reject", int'(lvl_reject), 0);
        chk("R1 seq_idle", int'(seq_idle), 1);

        // R2 rejection at the boundary delay 20 for level 2
        dly_cmd(20);
        lvl_cmd(2);
        chk("R2 rejected keeps level", int'(lvl_now), 0);
        chk("R2 reject flag", int'(lvl_reject), 1);
        lvl_cmd(1);
        chk("R2 level 1 accepted", int'(lvl_now), 1);
        // R3 same-cycle write and request judged on old delay
        dly_wr = 1'b1; dly_val = 8'd25; lvl_req_valid = 1'b1; lvl_req = 2'd2;
        step();
        dly_wr = 1'b0; lvl_req_valid = 1'b0;
        chk("R3 old delay judges request", int'(lvl_now), 1);
        lvl_cmd(2);
        chk("R3 new delay admits level 2", int'(lvl_now), 2);
        m_dly = 25; m_lvl = 2; m_err = 1;

        // R2 R3 random idle-time traffic against the model
        for (int it = 0; it < 300; it++) begin
            int unsigned w, v, rv, rl;
            w = $urandom % 2; v = $urandom % 41; rv = $urandom % 2; rl = $urandom % 4;
            dly_wr = w[0]; dly_val = 8'(v); lvl_req_valid = rv[0]; lvl_req = 2'(rl);
            step();
            if (rv != 0) begin
                if (exp_ok(int'(rl), m_dly)) m_lvl = int'(rl);
                else m_err = 1;
            end
            if (w != 0) m_dly = int'(v);
            chk("R2 random level", int'(lvl_now), m_lvl);
            chk("R2 random flag", int'(lvl_reject), m_err);
        end
        dly_wr = 1'b0; lvl_req_valid = 1'b0;

        // R4 R7 level 2, supplies already up
        dly_cmd(30);
        lvl_cmd(2);
        rise_measure("R4 delay 30 level 2", 30);
        fall_check("R7 level 2", 2);

        // R5 level 2 restore with all steps timing out
        reg_done = 1'b0; pll_done = 1'b0; tune_done = 1'b0;
        rise_measure("R5 timeouts 16 each", 49);
        reg_done = 1'b1; pll_done = 1'b1; tune_done = 1'b1;
        fall_check("R7 level 2 again", 2);

        // R5 level 0 frame still restores what is off
        lvl_cmd(0);
        rise_measure("R5 restore at level 0", 30);
        fall_check("R7 level 0", 0);

        // R4 minimum of one cycle
        dly_cmd(0);
        rise_measure("R4 delay 0", 1);
        fall_check("R7 level 0 short", 0);

        // R6 forced tune at level 0, tuning times out
        dly_cmd(5);
        tune_force = 1'b1; tune_done = 1'b0;
        rise_measure("R6 forced tune", 17);
        chk("R6 tune seen", int'(tune_seen), 1);
        fall_check("R7 after forced tune", 0);
        tune_force = 1'b0; tune_done = 1'b1;
        rise_measure("R6 no forced tune", 5);
        chk("R6 no tune", int'(tune_seen), 0);
        fall_check("R7 after plain frame", 0);

        // R3 write during an active frame is ignored
        dly_cmd(30);
        lvl_cmd(1);
        rise_measure("R4 level 1", 30);
        dly_cmd(3);
        fall_check("R7 level 1", 1);
        rise_measure("R3 ignored write", 30);

        // R8 enable rise held during power-down
        ch_en = 1'b0;
        step();
        step();
        ch_en = 1'b1;
        for (int i = 2; i < 41; i++) begin
            step();
            if (i == 6) chk("R8 pll before idle", int'(pll_on), 1);
            if (i == 7) begin
                chk("R8 pll off at idle", int'(pll_on), 0);
                chk("R8 idle reached", int'(seq_idle), 1);
            end
            if (i == 8) chk("R8 pll restarts", int'(pll_on), 1);
            if (i == 37) chk("R8 ana still off", int'(ana_on), 0);
            if (i == 38) chk("R8 ana on", int'(ana_on), 1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule